// File: doc/BRIEF.md
# Sequenced RNG Control Loader

This block programs the single shared control register of a random number source from a packet of four 64-bit words. Software hands over the packet with a start pulse. The loader captures it and writes the words one after another, always in index order 0, 1, 2, 3. After each write is accepted, it reads the register back until a read succeeds. This proves the write has settled before the next word goes out.

By convention, the first three words each select the oscillator setting of one entropy cell and turn on that cell alone. The last word sets the final operating mode with all three cells enabled. The loader passes every word through unchanged.

Every register access can come back with one of four responses:

- ok
- busy
- would-block
- a hard failure

Busy responses are retried after a short fixed pause. Would-block responses are retried after the tick count that comes with the response. Each of these two kinds has its own counter and its own limit. When the packet is finished, a one-cycle done pulse carries a 2-bit outcome.

Top module: `rng_ctl_loader`

## Requirements
- R1: After reset, `active`, `done`, `reg_wr_req` and `reg_rd_req` are low. In the cycle after a `done` pulse, `active` is low again.
- R2: Each write request is a one-cycle pulse on `reg_wr_req`. `reg_wr_data` carries the word at the current index. Words go out in order 0, 1, 2, 3, and a retried write carries the same word again.
- R3: A response with `rsp_code` 0 (ok) is handled as follows:
  - To a write: a read request follows in the next cycle.
  - To a read of word 0, 1 or 2: the write of the next word follows in the next cycle.
  - To the read of word 3: `done` rises in the next cycle with `status` 0.
- R4: A response with `rsp_code` 1 (busy) causes the same request to be issued again BUSY_GAP+2 cycles after the response cycle.
- R5: The BUSY_LIMIT-th busy response within one packet raises `done` in the next cycle with `status` 1. No further request follows.
- R6: A response with `rsp_code` 2 (would-block) and tick count T causes the same request to be issued again T+2 cycles after the response cycle.
- R7: The BLOCK_LIMIT-th would-block response within one packet raises `done` in the next cycle with `status` 2.
- R8: A response with `rsp_code` 3 raises `done` in the next cycle with `status` 3. No retry is made.
- R9: `start` is accepted only while idle. The packet is captured in the accepting cycle. A `start` pulse while `active` is high changes neither the words written nor the number of `done` pulses.
- R10: `done` never lasts more than one cycle. `reg_wr_req` and `reg_rd_req` are never high together. The `status` encoding is 0 ok, 1 busy, 2 would-block, 3 no device.
- R11: The busy counter and the would-block counter are separate and are cleared when each packet is accepted. BUSY_LIMIT-1 busy responses mixed with BLOCK_LIMIT-1 would-block responses still end with `status` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin loading the packet on `pkt_in` (only while idle) |
| pkt_in | input | 256 | Four control words; word i sits at bits 64*i+63 down to 64*i |
| active | output | 1 | High from acceptance until the done cycle inclusive |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | Outcome, valid with `done`: 0 ok, 1 busy, 2 would-block, 3 no device |
| reg_wr_req | output | 1 | Write request pulse to the control register |
| reg_rd_req | output | 1 | Read-back request pulse to the control register |
| reg_wr_data | output | 64 | Word being written |
| rsp_valid | input | 1 | Response strobe for the outstanding request |
| rsp_code | input | 2 | 0 ok, 1 busy, 2 would-block, 3 other failure |
| rsp_ticks | input | 16 | Wait time in cycles returned with a would-block response |

## Verification
The assertions assume that the register side answers each request with exactly one `rsp_valid` strobe. They also assume that the strobe comes no earlier than the cycle after the request and never while no request is outstanding. The bench responder enforces both: it arms a single pending reply only when it sees a request, and it delays that reply by zero or more cycles beyond the next one. The bench scripts response codes, tick counts and reply latencies in request order. It never produces a strobe outside that scheme.

// File: rtl/rcl_pkg.sv
package rcl_pkg;

  localparam int WORD_W    = 64;
  localparam int NUM_WORDS = 4;

  typedef enum logic [1:0] {
    RSP_OK   = 2'd0,
    RSP_BUSY = 2'd1,
    RSP_WBLK = 2'd2,
    RSP_FAIL = 2'd3
  } rsp_e;

  typedef enum logic [1:0] {
    ST_OK    = 2'd0,
    ST_BUSY  = 2'd1,
    ST_WBLK  = 2'd2,
    ST_NODEV = 2'd3
  } st_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WR_ISSUE,
    S_WR_WAIT,
    S_RD_ISSUE,
    S_RD_WAIT,
    S_HOLD,
    S_DONE
  } fsm_e;

  // Outcome reported when a non-ok response ends the packet.
  function automatic st_e fail_status(rsp_e k);
    case (k)
      RSP_BUSY: fail_status = ST_BUSY;
      RSP_WBLK: fail_status = ST_WBLK;
      default:  fail_status = ST_NODEV;
    endcase
  endfunction

endpackage

// File: rtl/ldr_retry_ctr.sv
module ldr_retry_ctr #(
  parameter int LIMIT = 100,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] cnt,
  output logic          last
);

  // last: the next response of this kind reaches the limit
  assign last = (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (clr)        cnt <= '0;
    else if (inc && !last) cnt <= cnt + CW'(1);
  end

endmodule

// File: rtl/ldr_backoff_timer.sv
module ldr_backoff_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] val,
  output logic          zero
);

  logic [TW-1:0] left_q;

  assign zero = (left_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)     left_q <= '0;
    else if (load)  left_q <= val;
    else if (!zero) left_q <= left_q - TW'(1);
  end

endmodule

// File: rtl/ldr_word_pick.sv
module ldr_word_pick #(
  parameter int W = 64,
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N*W-1:0] pkt,
  input  logic [IW-1:0]  idx,
  output logic [W-1:0]   word
);

  logic [W-1:0] slot [N];

  for (genvar g = 0; g < N; g++) begin : g_slot
    assign slot[g] = pkt[g*W +: W];
  end

  assign word = slot[idx];

endmodule

// File: rtl/rng_ctl_loader.sv
module rng_ctl_loader
  import rcl_pkg::*;
#(
  parameter int BUSY_LIMIT  = 100,
  parameter int BLOCK_LIMIT = 10000,
  parameter int BUSY_GAP    = 8,
  parameter int TICK_W      = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [NUM_WORDS*WORD_W-1:0] pkt_in,
  output logic                        active,
  output logic                        done,
  output logic [1:0]                  status,
  output logic                        reg_wr_req,
  output logic                        reg_rd_req,
  output logic [WORD_W-1:0]           reg_wr_data,
  input  logic                        rsp_valid,
  input  logic [1:0]                  rsp_code,
  input  logic [TICK_W-1:0]           rsp_ticks
);

  localparam int IDX_W = $clog2(NUM_WORDS);
  localparam int BW    = $clog2(BUSY_LIMIT + 1);
  localparam int KW    = $clog2(BLOCK_LIMIT + 1);
  localparam int PKT_W = NUM_WORDS * WORD_W;
  localparam logic [TICK_W-1:0] GAP_T = TICK_W'(BUSY_GAP);

  fsm_e             state_q, state_d;
  logic [IDX_W-1:0] idx_q;
  logic             ret_rd_q;
  st_e              status_q;
  logic [PKT_W-1:0] pkt_q;

  // named internal events
  logic accept, in_wait, rsp_take, busy_hit, block_hit;
  logic busy_last, block_last, tmr_zero, last_word;
  logic idx_adv, end_now, hold_go;
  st_e  end_st;
  rsp_e kind;
  logic [TICK_W-1:0] tmr_val;
  logic [BW-1:0] busy_cnt;
  logic [KW-1:0] block_cnt;

  assign kind      = rsp_e'(rsp_code);
  assign accept    = (state_q == S_IDLE) && start;
  assign in_wait   = (state_q == S_WR_WAIT) || (state_q == S_RD_WAIT);
  assign rsp_take  = in_wait && rsp_valid;
  assign busy_hit  = rsp_take && (kind == RSP_BUSY);
  assign block_hit = rsp_take && (kind == RSP_WBLK);
  assign last_word = (idx_q == IDX_W'(NUM_WORDS - 1));
  assign tmr_val   = (kind == RSP_BUSY) ? GAP_T : rsp_ticks;

  always_comb begin
    state_d = state_q;
    idx_adv = 1'b0;
    end_now = 1'b0;
    end_st  = ST_OK;
    hold_go = 1'b0;
    case (state_q)
      S_IDLE:     if (start) state_d = S_WR_ISSUE;
      S_WR_ISSUE: state_d = S_WR_WAIT;
      S_RD_ISSUE: state_d = S_RD_WAIT;
      S_WR_WAIT, S_RD_WAIT: begin
        if (rsp_valid) begin
          case (kind)
            RSP_OK: begin
              if (state_q == S_WR_WAIT) state_d = S_RD_ISSUE;
              else if (last_word)       end_now = 1'b1;
              else begin
                idx_adv = 1'b1;
                state_d = S_WR_ISSUE;
              end
            end
            RSP_BUSY: begin
              if (busy_last) begin
                end_now = 1'b1;
                end_st  = fail_status(kind);
              end else hold_go = 1'b1;
            end
            RSP_WBLK: begin
              if (block_last) begin
                end_now = 1'b1;
                end_st  = fail_status(kind);
              end else hold_go = 1'b1;
            end
            default: begin
              end_now = 1'b1;
              end_st  = fail_status(kind);
            end
          endcase
          if (end_now)      state_d = S_DONE;
          else if (hold_go) state_d = S_HOLD;
        end
      end
      S_HOLD:  if (tmr_zero) state_d = ret_rd_q ? S_RD_ISSUE : S_WR_ISSUE;
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      idx_q    <= '0;
      ret_rd_q <= 1'b0;
      status_q <= ST_OK;
      pkt_q    <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        pkt_q <= pkt_in;
        idx_q <= '0;
      end else if (idx_adv) begin
        idx_q <= idx_q + IDX_W'(1);
      end
      if (hold_go) ret_rd_q <= (state_q == S_RD_WAIT);
      if (end_now) status_q <= end_st;
    end
  end

  ldr_retry_ctr #(.LIMIT(BUSY_LIMIT)) u_busy_ctr (
    .clk(clk), .rst_n(rst_n), .clr(accept), .inc(busy_hit),
    .cnt(busy_cnt), .last(busy_last)
  );

  ldr_retry_ctr #(.LIMIT(BLOCK_LIMIT)) u_block_ctr (
    .clk(clk), .rst_n(rst_n), .clr(accept), .inc(block_hit),
    .cnt(block_cnt), .last(block_last)
  );

  ldr_backoff_timer #(.TW(TICK_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(hold_go), .val(tmr_val), .zero(tmr_zero)
  );

  ldr_word_pick #(.W(WORD_W), .N(NUM_WORDS)) u_pick (
    .pkt(pkt_q), .idx(idx_q), .word(reg_wr_data)
  );

  assign active     = (state_q != S_IDLE);
  assign done       = (state_q == S_DONE);
  assign status     = status_q;
  assign reg_wr_req = (state_q == S_WR_ISSUE);
  assign reg_rd_req = (state_q == S_RD_ISSUE);

endmodule

// File: rtl/rng_ctl_loader_chk.sv
module rng_ctl_loader_chk #(
  parameter int BUSY_LIMIT  = 100,
  parameter int BLOCK_LIMIT = 10000,
  parameter int BW          = 7,
  parameter int KW          = 14,
  parameter int PKT_W       = 256
) (
  input logic             clk,
  input logic             rst_n,
  input logic             active,
  input logic             done,
  input logic [1:0]       status,
  input logic             reg_wr_req,
  input logic             reg_rd_req,
  input logic             rsp_take,
  input logic [1:0]       rsp_code,
  input logic [BW-1:0]    busy_cnt,
  input logic [KW-1:0]    block_cnt,
  input logic [PKT_W-1:0] pkt_q
);

  // R10
  one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_req && reg_rd_req));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_req |=> !reg_wr_req);

  // R1
  idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !active);

  // R8
  nodev_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_take && rsp_code == 2'd3) |=> (done && status == 2'd3));

  // R3
  done_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(rsp_take));

  // R5
  busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cnt < BW'(BUSY_LIMIT));

  // R7
  block_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    block_cnt < KW'(BLOCK_LIMIT));

  // R9
  pkt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> $stable(pkt_q));

endmodule

bind rng_ctl_loader rng_ctl_loader_chk #(
  .BUSY_LIMIT(BUSY_LIMIT), .BLOCK_LIMIT(BLOCK_LIMIT),
  .BW(BW), .KW(KW), .PKT_W(PKT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .active(active), .done(done), .status(status),
  .reg_wr_req(reg_wr_req), .reg_rd_req(reg_rd_req), .rsp_take(rsp_take),
  .rsp_code(rsp_code), .busy_cnt(busy_cnt), .block_cnt(block_cnt),
  .pkt_q(pkt_q)
);

// File: tb/rng_ctl_loader_test.sv
module rng_ctl_loader_test;

  localparam int BL  = 4;
  localparam int KL  = 5;
  localparam int GAP = 8;
  localparam int TW  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [255:0] pkt_in = '0;
  logic active, done, reg_wr_req, reg_rd_req;
  logic [1:0] status;
  logic [63:0] reg_wr_data;
  logic rsp_valid = 1'b0;
  logic [1:0] rsp_code = 2'd0;
  logic [TW-1:0] rsp_ticks = '0;

  always #4 clk = ~clk;

  rng_ctl_loader #(.BUSY_LIMIT(BL), .BLOCK_LIMIT(KL), .BUSY_GAP(GAP), .TICK_W(TW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .pkt_in(pkt_in), .active(active),
    .done(done), .status(status), .reg_wr_req(reg_wr_req), .reg_rd_req(reg_rd_req),
    .reg_wr_data(reg_wr_data), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
    .rsp_ticks(rsp_ticks)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 0;

  typedef struct { logic [1:0] code; int ticks; int lat; } rsp_t;
  rsp_t script[$];
  logic [63:0] exp_wq[$];
  logic [1:0]  exp_sq[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_gap(logic [1:0] code, int ticks);
    case (code)
      2'd1:    return GAP + 2;
      2'd2:    return ticks + 2;
      default: return 1;
    endcase
  endfunction

  function automatic string gap_tag(logic [1:0] code);
    case (code)
      2'd1:    return "R4";
      2'd2:    return "R6";
      default: return "R3";
    endcase
  endfunction

  function automatic string st_tag(logic [1:0] st);
    case (st)
      2'd1:    return "R5";
      2'd2:    return "R7";
      2'd3:    return "R8";
      default: return "R3";
    endcase
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  // responder + monitor
  int pend = -1;
  rsp_t cur;
  bit cur_rd = 0;
  bit have_rsp = 0;
  bit last_req_rd = 0;
  int last_cyc = 0;
  logic [1:0] last_code = 2'd0;
  int last_ticks = 0;
  int n_req = 0;
  int n_done = 0;

  always @(negedge clk) begin
    rsp_valid = 1'b0;
    if (pend == 0) begin
      rsp_valid = 1'b1;
      rsp_code  = cur.code;
      rsp_ticks = TW'(cur.ticks);
      have_rsp = 1;
      last_cyc = cyc;
      last_code = cur.code;
      last_ticks = cur.ticks;
      if (cur.code == 2'd0 && cur_rd && exp_wq.size() > 0) void'(exp_wq.pop_front());
      pend = -1;
    end else if (pend > 0) begin
      pend--;
    end
    if (reg_wr_req || reg_rd_req) begin
      n_req++;
      if (have_rsp) begin
        chk(cyc - last_cyc == exp_gap(last_code, last_ticks), gap_tag(last_code),
            "request gap", cyc - last_cyc, exp_gap(last_code, last_ticks));
        if (last_code == 2'd0)
          chk(reg_rd_req == !last_req_rd, "R3", "request kind after ok",
              reg_rd_req, !last_req_rd);
        else
          chk(reg_rd_req == last_req_rd, gap_tag(last_code), "retry kind",
              reg_rd_req, last_req_rd);
      end else begin
        chk(reg_wr_req, "R2", "first request is a write", reg_wr_req, 1);
      end
      if (reg_wr_req)
        chk(exp_wq.size() > 0 && reg_wr_data == exp_wq[0], "R2", "write data",
            reg_wr_data, (exp_wq.size() > 0) ? exp_wq[0] : 64'hx);
      last_req_rd = reg_rd_req;
      cur = (script.size() > 0) ? script.pop_front() : '{2'd0, 0, 0};
      cur_rd = reg_rd_req;
      pend = cur.lat;
    end
    if (done) begin
      logic [1:0] es;
      n_done++;
      es = (exp_sq.size() > 0) ? exp_sq.pop_front() : 2'd0;
      chk(have_rsp && cyc - last_cyc == 1, "R3", "done one cycle after response",
          cyc - last_cyc, 1);
      chk(status == es, st_tag(es), "status", status, es);
      if (es == 2'd0) chk(exp_wq.size() == 0, "R2", "words left", exp_wq.size(), 0);
      exp_wq.delete();
      have_rsp = 0;
    end
  end

  function automatic logic [63:0] mk_word(int seed, int i);
    logic [63:0] w;
    w = 64'(seed) << 32;
    if (i < 3) w = w | (64'(i + 1) << 8) | (64'd1 << i);
    else       w = w | 64'h17;
    return w;
  endfunction

  task automatic add_rsp(input logic [1:0] code, input int ticks, input int lat);
    script.push_back('{code, ticks, lat});
  endtask

  task automatic launch(input int seed, input logic [1:0] st);
    for (int i = 0; i < 4; i++) begin
      exp_wq.push_back(mk_word(seed, i));
      pkt_in[i*64 +: 64] = mk_word(seed, i);
    end
    exp_sq.push_back(st);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input int d0);
    while (n_done == d0) @(negedge clk);
    @(negedge clk);
    chk(!active, "R1", "active after done", active, 0);
  endtask

  task automatic run_pkt(input int seed, input logic [1:0] st);
    int d0;
    d0 = n_done;
    launch(seed, st);
    wait_done(d0);
    chk(script.size() == 0, "R10", "script consumed", script.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!active, "R1", "active in reset", active, 0);
    chk(!done, "R1", "done in reset", done, 0);
    chk(!reg_wr_req && !reg_rd_req, "R1", "requests in reset", reg_wr_req, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!active && !reg_wr_req && !reg_rd_req, "R1", "idle after reset", active, 0);

    // R3 clean packet
    run_pkt(1, 2'd0);

    // R4 R6 mixed retries with latencies
    add_rsp(2'd1, 0, 1);   // w0 busy
    add_rsp(2'd0, 0, 0);   // w0 ok
    add_rsp(2'd2, 3, 0);   // r0 would-block
    add_rsp(2'd0, 0, 2);   // r0 ok
    add_rsp(2'd0, 0, 2);   // w1 ok
    add_rsp(2'd2, 0, 0);   // r1 would-block, zero ticks
    add_rsp(2'd0, 0, 0);   // r1 ok
    add_rsp(2'd2, 40, 1);  // w2 would-block, long wait
    run_pkt(2, 2'd0);

    // R5 busy limit
    begin
      int r0;
      add_rsp(2'd0, 0, 0);
      add_rsp(2'd0, 0, 0);
      for (int i = 0; i < BL; i++) add_rsp(2'd1, 0, 0);
      run_pkt(3, 2'd1);
      r0 = n_req;
      repeat (20) @(negedge clk);
      chk(n_req == r0, "R5", "requests after busy end", n_req - r0, 0);
    end

    // R7 would-block limit
    add_rsp(2'd0, 0, 0);
    for (int i = 0; i < KL; i++) add_rsp(2'd2, 2, 0);
    run_pkt(4, 2'd2);

    // R11 separate counters
    for (int i = 0; i < 3; i++) begin
      add_rsp(2'd1, 0, 0);
      add_rsp(2'd2, 1, 0);
    end
    add_rsp(2'd2, 1, 0);
    run_pkt(5, 2'd0);
    // R11 counters cleared per packet
    for (int i = 0; i < BL - 1; i++) add_rsp(2'd1, 0, 0);
    run_pkt(6, 2'd0);

    // R8 hard failure on read of word 2
    for (int i = 0; i < 5; i++) add_rsp(2'd0, 0, 0);
    add_rsp(2'd3, 0, 1);
    run_pkt(7, 2'd3);

    // R9 start ignored while active
    begin
      int d0;
      d0 = n_done;
      add_rsp(2'd1, 0, 0);
      launch(8, 2'd0);
      repeat (5) @(negedge clk);
      for (int i = 0; i < 4; i++) pkt_in[i*64 +: 64] = mk_word(99, i);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done(d0);
      repeat (30) @(negedge clk);
      chk(n_done == d0 + 1, "R9", "done count", n_done - d0, 1);
      chk(!active, "R9", "no restart from ignored start", active, 0);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R10 watchdog: actual=%0d expected=%0d", n_done, -1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule